// File: doc/BRIEF.md
# Low-Power Mode and Pin-State Controller

This block puts a small microcontroller core into its two reduced-power states and brings it back out. The core writes a whole byte to a power-control register. If that byte sets the idle bit, the CPU clock stops while the oscillator and the peripheral clocks keep running. If it sets the power-down bit, the oscillator enable drops as well, so everything freezes. An enabled interrupt ends idle. Only a hardware reset ends power-down.

While the core is in a reduced-power state, the block overrides the sources of the address-latch strobe, the program-store strobe, port 0, port 2 and the PWM pins. What each pin shows depends on the current mode and on whether code is being fetched from external program memory. In normal running, every pin source passes through from the core unchanged.

Top module: `lowpwr_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_o` is 0 (run), `pcon_o` is 0, and `osc_en`, `cpu_clk_en` and `per_clk_en` are all 1.
- R2: A byte write accepted in run mode appears on `pcon_o` on the next cycle. If bit 1 of the byte is set, `mode_o` becomes 2 (power-down) on the next cycle, and all three enables are then 0.
- R3: A run-mode write with bit 0 set and bit 1 clear moves `mode_o` to 1 (idle) on the next cycle. In idle, `cpu_clk_en` is 0 while `osc_en` and `per_clk_en` stay 1.
- R4: A write with both bit 0 and bit 1 set enters power-down, not idle.
- R5: In idle, `irq_wake` returns `mode_o` to 0 on the next cycle. It also clears bit 0 of `pcon_o` and keeps every other bit.
- R6: In power-down, `irq_wake` and register writes have no effect: the mode and `pcon_o` hold. Only `rst` returns the block to run mode, and it reloads `pcon_o` with 0.
- R7: `ale_o` and `psen_o` follow `cpu_ale` and `cpu_psen` in run mode. Both are 1 in idle and both are 0 in power-down.
- R8: In idle and power-down, port 0 behaves as follows:
  - with `ext_fetch`=1, it floats (`p0_oe`=0, `p0_o`=0);
  - with `ext_fetch`=0, it drives `p0_latch` (`p0_oe`=1).
  In run mode, `p0_o` and `p0_oe` follow `p0_norm` and `p0_norm_oe`.
- R9: In run and idle, `p2_o` is `p2_addr` when `ext_fetch`=1 and `p2_latch` otherwise. In power-down, `p2_o` is always `p2_latch`.
- R10: Every PWM output is forced to 1 in idle and power-down, and follows `pwm_norm` in run.
- R11: Register writes in idle are ignored. A run-mode write with bits 1:0 both clear, and `irq_wake` in run mode, leave the mode at run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr | input | 1 | Byte write strobe to the power-control register |
| reg_wdata | input | 8 | Write data; bit 0 idle, bit 1 power-down |
| irq_wake | input | 1 | An enabled interrupt is pending |
| ext_fetch | input | 1 | 1 when fetching from external program memory |
| cpu_ale | input | 1 | Address-latch strobe from the core |
| cpu_psen | input | 1 | Program-store strobe from the core |
| p0_norm | input | 8 | Port 0 value in run mode |
| p0_norm_oe | input | 1 | Port 0 drive enable in run mode |
| p0_latch | input | 8 | Port 0 latch contents |
| p2_addr | input | 8 | High address byte for external fetch |
| p2_latch | input | 8 | Port 2 latch contents |
| pwm_norm | input | 2 | PWM pin values in run mode |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_o | output | 2 | 0 run, 1 idle, 2 power-down |
| pcon_o | output | 8 | Power-control register contents |
| ale_o | output | 1 | Address-latch strobe pin source |
| psen_o | output | 1 | Program-store strobe pin source |
| p0_o | output | 8 | Port 0 pin value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_o | output | 8 | Port 2 pin value |
| pwm_o | output | 2 | PWM pin sources |

## Verification
The hardest situation to reach is power-down with external fetch. That is the one case where port 2 stops showing the address byte, so it only shows up if the bench sets distinct values on `p2_addr` and `p2_latch` and drives `ext_fetch` high after entry. The same applies to the claim that nothing but reset leaves power-down. To test it, the bench first enters power-down. It then fires a wake pulse and a clearing byte write, and checks that `mode_o` and `pcon_o` are unchanged. Only after that does it reset. Idle is walked through the same way: a write arrives while idle and must be dropped, and the wake that follows must clear only bit 0.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } lpm_mode_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic per;
    } lpm_clk_en_s;

    // Clock enables implied by each mode
    function automatic lpm_clk_en_s clk_en_for(lpm_mode_e m);
        lpm_clk_en_s e;
        case (m)
            MODE_IDLE:  e = '{osc: 1'b1, cpu: 1'b0, per: 1'b1};
            MODE_PDOWN: e = '{osc: 1'b0, cpu: 1'b0, per: 1'b0};
            default:    e = '{osc: 1'b1, cpu: 1'b1, per: 1'b1};
        endcase
        return e;
    endfunction

    // Power-down outranks idle when both bits arrive together
    function automatic lpm_mode_e mode_on_write(logic want_idle, logic want_pd);
        if (want_pd)
            return MODE_PDOWN;
        else if (want_idle)
            return MODE_IDLE;
        else
            return MODE_RUN;
    endfunction

endpackage

// File: rtl/lpm_pcon_reg.sv
module lpm_pcon_reg
    import lpm_pkg::*;
#(
    parameter int PCON_W   = 8,
    parameter int IDLE_BIT = 0,
    parameter int PD_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  lpm_mode_e         mode_i,
    input  logic              wr_i,
    input  logic [PCON_W-1:0] wdata_i,
    input  logic              wake_i,
    output logic [PCON_W-1:0] pcon_o,
    output logic              req_idle_o,
    output logic              req_pd_o
);

    logic              accept;
    logic              wake_clear;
    logic [PCON_W-1:0] pcon_q;

    // Only a running CPU can issue a write
    assign accept     = wr_i && (mode_i == MODE_RUN);
    assign wake_clear = wake_i && (mode_i == MODE_IDLE);
    assign req_idle_o = accept && wdata_i[IDLE_BIT];
    assign req_pd_o   = accept && wdata_i[PD_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            pcon_q <= '0;
        else if (accept)
            pcon_q <= wdata_i;
        else if (wake_clear)
            pcon_q[IDLE_BIT] <= 1'b0;
    end

    assign pcon_o = pcon_q;

    // R6
    pd_hold_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_PDOWN) |=> $stable(pcon_q));

    // R5
    wake_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_IDLE && wake_i) |=> !pcon_q[IDLE_BIT]);

    // R11
    idle_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_IDLE && !wake_i) |=> $stable(pcon_q));

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_idle_i,
    input  logic      req_pd_i,
    input  logic      wake_i,
    output lpm_mode_e mode_o,
    output logic      osc_en_o,
    output logic      cpu_en_o,
    output logic      per_en_o
);

    lpm_mode_e   mode_q, mode_d;
    lpm_clk_en_s en;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_RUN:   mode_d = mode_on_write(req_idle_i, req_pd_i);
            MODE_IDLE:  if (wake_i) mode_d = MODE_RUN;
            MODE_PDOWN: mode_d = MODE_PDOWN;
            default:    mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_RUN;
        else
            mode_q <= mode_d;
    end

    assign en       = clk_en_for(mode_q);
    assign mode_o   = mode_q;
    assign osc_en_o = en.osc;
    assign cpu_en_o = en.cpu;
    assign per_en_o = en.per;

    // R6
    pd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PDOWN) |=> (mode_q == MODE_PDOWN));

    // R5
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDLE && wake_i) |=> (mode_q == MODE_RUN));

    // R4
    pd_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && req_pd_i) |=> (mode_q == MODE_PDOWN));

    // R3
    idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && req_idle_i && !req_pd_i) |=> (mode_q == MODE_IDLE));

    // R3
    idle_osc_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDLE) |-> (osc_en_o && per_en_o && !cpu_en_o));

endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux
    import lpm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PWM_N  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  lpm_mode_e         mode_i,
    input  logic              ext_fetch_i,
    input  logic              cpu_ale_i,
    input  logic              cpu_psen_i,
    input  logic [DATA_W-1:0] p0_norm_i,
    input  logic              p0_norm_oe_i,
    input  logic [DATA_W-1:0] p0_latch_i,
    input  logic [DATA_W-1:0] p2_addr_i,
    input  logic [DATA_W-1:0] p2_latch_i,
    input  logic [PWM_N-1:0]  pwm_norm_i,
    output logic              ale_o,
    output logic              psen_o,
    output logic [DATA_W-1:0] p0_o,
    output logic              p0_oe_o,
    output logic [DATA_W-1:0] p2_o,
    output logic [PWM_N-1:0]  pwm_o
);

    logic in_idle, in_pd, held;

    assign in_idle = (mode_i == MODE_IDLE);
    assign in_pd   = (mode_i == MODE_PDOWN);
    assign held    = in_idle || in_pd;

    // Strobes: pass-through, high in idle, low in power-down
    always_comb begin
        if (in_pd) begin
            ale_o  = 1'b0;
            psen_o = 1'b0;
        end else if (in_idle) begin
            ale_o  = 1'b1;
            psen_o = 1'b1;
        end else begin
            ale_o  = cpu_ale_i;
            psen_o = cpu_psen_i;
        end
    end

    // Port 0: floats under external fetch while held
    always_comb begin
        if (!held) begin
            p0_o    = p0_norm_i;
            p0_oe_o = p0_norm_oe_i;
        end else if (ext_fetch_i) begin
            p0_o    = '0;
            p0_oe_o = 1'b0;
        end else begin
            p0_o    = p0_latch_i;
            p0_oe_o = 1'b1;
        end
    end

    // Port 2: the address byte is replaced by the latch only in power-down
    always_comb begin
        if (ext_fetch_i && !in_pd)
            p2_o = p2_addr_i;
        else
            p2_o = p2_latch_i;
    end

    for (genvar i = 0; i < PWM_N; i++) begin : g_pwm
        assign pwm_o[i] = held ? 1'b1 : pwm_norm_i[i];
    end

    // R7
    pd_strobes_low_chk: assert property (@(posedge clk) disable iff (rst)
        in_pd |-> (!ale_o && !psen_o));

    // R9
    pd_port2_latch_chk: assert property (@(posedge clk) disable iff (rst)
        in_pd |-> (p2_o == p2_latch_i));

    // R8
    ext_p0_float_chk: assert property (@(posedge clk) disable iff (rst)
        (held && ext_fetch_i) |-> !p0_oe_o);

endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
    import lpm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PWM_N    = 2,
    parameter int IDLE_BIT = 0,
    parameter int PD_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              irq_wake,
    input  logic              ext_fetch,
    input  logic              cpu_ale,
    input  logic              cpu_psen,
    input  logic [DATA_W-1:0] p0_norm,
    input  logic              p0_norm_oe,
    input  logic [DATA_W-1:0] p0_latch,
    input  logic [DATA_W-1:0] p2_addr,
    input  logic [DATA_W-1:0] p2_latch,
    input  logic [PWM_N-1:0]  pwm_norm,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] pcon_o,
    output logic              ale_o,
    output logic              psen_o,
    output logic [DATA_W-1:0] p0_o,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_o,
    output logic [PWM_N-1:0]  pwm_o
);

    lpm_mode_e mode;
    logic      req_idle, req_pd;

    lpm_pcon_reg #(
        .PCON_W  (DATA_W),
        .IDLE_BIT(IDLE_BIT),
        .PD_BIT  (PD_BIT)
    ) u_pcon (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .wr_i      (reg_wr),
        .wdata_i   (reg_wdata),
        .wake_i    (irq_wake),
        .pcon_o    (pcon_o),
        .req_idle_o(req_idle),
        .req_pd_o  (req_pd)
    );

    lpm_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_idle_i(req_idle),
        .req_pd_i  (req_pd),
        .wake_i    (irq_wake),
        .mode_o    (mode),
        .osc_en_o  (osc_en),
        .cpu_en_o  (cpu_clk_en),
        .per_en_o  (per_clk_en)
    );

    lpm_pin_mux #(
        .DATA_W(DATA_W),
        .PWM_N (PWM_N)
    ) u_pins (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .ext_fetch_i (ext_fetch),
        .cpu_ale_i   (cpu_ale),
        .cpu_psen_i  (cpu_psen),
        .p0_norm_i   (p0_norm),
        .p0_norm_oe_i(p0_norm_oe),
        .p0_latch_i  (p0_latch),
        .p2_addr_i   (p2_addr),
        .p2_latch_i  (p2_latch),
        .pwm_norm_i  (pwm_norm),
        .ale_o       (ale_o),
        .psen_o      (psen_o),
        .p0_o        (p0_o),
        .p0_oe_o     (p0_oe),
        .p2_o        (p2_o),
        .pwm_o       (pwm_o)
    );

    assign mode_o = mode;

    // R2
    pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && reg_wr && reg_wdata[PD_BIT]) |=> (mode_o == 2'd2 && !osc_en));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && reg_wr) |=> (pcon_o == $past(reg_wdata)));

endmodule

// File: tb/lowpwr_ctrl_test.sv
module lowpwr_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       irq_wake = 1'b0;
    logic       ext_fetch = 1'b0;
    logic       cpu_ale = 1'b0;
    logic       cpu_psen = 1'b0;
    logic [7:0] p0_norm = '0;
    logic       p0_norm_oe = 1'b0;
    logic [7:0] p0_latch = '0;
    logic [7:0] p2_addr = '0;
    logic [7:0] p2_latch = '0;
    logic [1:0] pwm_norm = '0;
    logic       osc_en, cpu_clk_en, per_clk_en;
    logic [1:0] mode_o;
    logic [7:0] pcon_o;
    logic       ale_o, psen_o;
    logic [7:0] p0_o;
    logic       p0_oe;
    logic [7:0] p2_o;
    logic [1:0] pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 0;

    lowpwr_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .irq_wake(irq_wake), .ext_fetch(ext_fetch), .cpu_ale(cpu_ale),
        .cpu_psen(cpu_psen), .p0_norm(p0_norm), .p0_norm_oe(p0_norm_oe),
        .p0_latch(p0_latch), .p2_addr(p2_addr), .p2_latch(p2_latch),
        .pwm_norm(pwm_norm), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .mode_o(mode_o), .pcon_o(pcon_o),
        .ale_o(ale_o), .psen_o(psen_o), .p0_o(p0_o), .p0_oe(p0_oe),
        .p2_o(p2_o), .pwm_o(pwm_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Each helper leaves the bench at a negedge, after the registering edge
    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic write_pcon(input logic [7:0] v);
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = v; end
        @(negedge clk) reg_wr = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) irq_wake = 1'b1;
        @(negedge clk) irq_wake = 1'b0;
    endtask

    task automatic set_pins();
        cpu_ale = 1'b1; cpu_psen = 1'b0;
        p0_norm = 8'h5A; p0_norm_oe = 1'b1; p0_latch = 8'h96;
        p2_addr = 8'h3C; p2_latch = 8'hC3; pwm_norm = 2'b01;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 pcon", pcon_o, 0);
        chk("R1 enables", {osc_en, cpu_clk_en, per_clk_en}, 3'b111);
    endtask

    task automatic t_run();
        set_pins();
        ext_fetch = 1'b1;
        write_pcon(8'hA4);
        chk("R2 pcon stored", pcon_o, 8'hA4);
        chk("R11 no-mode write stays run", mode_o, 0);
        pulse_wake();
        chk("R11 wake in run", mode_o, 0);
        chk("R11 wake in run pcon", pcon_o, 8'hA4);
        #1;
        chk("R7 run strobes", {ale_o, psen_o}, 2'b10);
        chk("R8 run p0", {p0_oe, p0_o}, {1'b1, 8'h5A});
        chk("R9 run p2 ext", p2_o, 8'h3C);
        chk("R10 run pwm", pwm_o, 2'b01);
        ext_fetch = 1'b0; #1;
        chk("R9 run p2 int", p2_o, 8'hC3);
    endtask

    task automatic t_idle();
        set_pins();
        ext_fetch = 1'b1;
        write_pcon(8'hF1);
        chk("R3 idle mode", mode_o, 1);
        chk("R3 idle enables", {osc_en, cpu_clk_en, per_clk_en}, 3'b101);
        chk("R7 idle strobes", {ale_o, psen_o}, 2'b11);
        chk("R8 idle ext p0 float", {p0_oe, p0_o}, {1'b0, 8'h00});
        chk("R9 idle ext p2 addr", p2_o, 8'h3C);
        chk("R10 idle pwm", pwm_o, 2'b11);
        ext_fetch = 1'b0; #1;
        chk("R8 idle int p0", {p0_oe, p0_o}, {1'b1, 8'h96});
        chk("R9 idle int p2", p2_o, 8'hC3);
        write_pcon(8'h02);
        chk("R11 idle write dropped pcon", pcon_o, 8'hF1);
        chk("R11 idle write dropped mode", mode_o, 1);
        pulse_wake();
        chk("R5 wake mode", mode_o, 0);
        chk("R5 wake pcon", pcon_o, 8'hF0);
        chk("R5 cpu clock back", cpu_clk_en, 1);
    endtask

    task automatic t_pdown();
        set_pins();
        ext_fetch = 1'b1;
        write_pcon(8'h02);
        chk("R2 pd mode", mode_o, 2);
        chk("R2 pd enables", {osc_en, cpu_clk_en, per_clk_en}, 3'b000);
        chk("R2 pd pcon", pcon_o, 8'h02);
        chk("R7 pd strobes", {ale_o, psen_o}, 2'b00);
        chk("R8 pd ext p0 float", {p0_oe, p0_o}, {1'b0, 8'h00});
        chk("R9 pd ext p2 latch", p2_o, 8'hC3);
        chk("R10 pd pwm", pwm_o, 2'b11);
        ext_fetch = 1'b0; #1;
        chk("R8 pd int p0", {p0_oe, p0_o}, {1'b1, 8'h96});
        pulse_wake();
        chk("R6 wake ignored", mode_o, 2);
        write_pcon(8'h00);
        chk("R6 write ignored mode", mode_o, 2);
        chk("R6 write ignored pcon", pcon_o, 8'h02);
        do_reset();
        chk("R6 reset exits", mode_o, 0);
        chk("R6 reset reloads pcon", pcon_o, 8'h00);
    endtask

    task automatic t_both();
        write_pcon(8'h03);
        chk("R4 both bits pd", mode_o, 2);
        chk("R4 both bits pcon", pcon_o, 8'h03);
        chk("R4 cpu off", cpu_clk_en, 0);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_run();
        t_idle();
        t_pdown();
        t_both();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule